// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that gives a bus controller access to a small bank of eight-bit control registers and one read-only status register. A fast system clock oversamples SCL and SDA through two-flop synchronizers. From the sampled lines the block detects start, repeated start and stop conditions. It acknowledges only its own fixed seven-bit address and drives SDA as an open-drain enable: when `sda_oe` is high, the line is pulled low.

A write transfer sends the address with the direction bit cleared, then a register pointer byte, then any number of data bytes. A read first sets the pointer in a write phase. The controller then issues a repeated start and the address with the direction bit set, and the target returns bytes MSB first until the controller answers one of them with NACK. The pointer advances after every data byte in both directions.

The stored register contents are presented as parallel field outputs. The speaker-fault and thermal status inputs are sampled into the byte that is returned whenever register 0 is read.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges (SDA low during the ninth clock) only the first byte 0xE0 (write) or 0xE1 (read), that is, address 0x70. For any other address it acknowledges nothing and changes no register until the next start.
- R2: In a write, the first byte after the address sets the pointer. Each following data byte is stored at the pointer, acknowledged, and then the pointer increments.
- R3: After a repeated start with 0xE1, the target drives the byte at the pointer MSB first. It changes SDA only while SCL is low, and the pointer increments after each byte.
- R4: When the controller answers a read byte with NACK (SDA high on the ninth clock), the target releases SDA and drives nothing more until the next start.
- R5: Register 0 reads as {version[3:0], 2'b00, speaker_fault, thermal}. The two flags are the input values sampled when the byte is loaded. The version is a parameter that defaults to 0.
- R6: Writes to register 0 and to pointer values 7 and above are ignored. Reads at pointer values 7 and above return 0x00.
- R7: The reserved bits (register 1 bit 5 and register 5 bit 5) are never set by writes. They stay 0 and read as 0.
- R8: After synchronous reset, all registers and outputs are 0 and SDA is released.
- R9: A stop, or a start in any state including mid-byte, abandons the current byte without storing it and returns the block to address matching.
- R10: The field outputs are decoded from the registers as follows: register 1 maps to ctl_flags; register 2 bits 7:3 and 2:0 map to atk_time and spk_lim; register 3 bits 7:3 and 2:0 map to rel_time and hp_lim; register 4 bits 7:5 and 4:0 map to amp_mode and mono_vol; registers 5 and 6 map to spk_gain_cfg and hp_gain_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (bus value) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| spk_fault_i | input | 1 | Speaker fault status flag |
| thermal_i | input | 1 | Thermal status flag |
| ctl_flags | output | 8 | Register 1 control bits (bit 5 reserved, 0) |
| atk_time | output | 5 | Register 2 time field |
| spk_lim | output | 3 | Register 2 limit level |
| rel_time | output | 5 | Register 3 time field |
| hp_lim | output | 3 | Register 3 limit level |
| amp_mode | output | 3 | Register 4 mode field |
| mono_vol | output | 5 | Register 4 volume field |
| spk_gain_cfg | output | 8 | Register 5 contents (bit 5 reserved, 0) |
| hp_gain_cfg | output | 8 | Register 6 contents |

## Verification
The hardest situations to reach from the ports are a transfer abandoned partway through a byte and the target's behaviour after a controller NACK. An abandoned transfer has a start or stop arriving while bits are half shifted. After a NACK, the target must keep SDA released while the bus is still being clocked. The bench's bit-level controller tasks can therefore send a chosen number of bits of a byte and then issue a stop or a repeated start. The bench then checks that no register changed and that the next normal transfer is acknowledged. After a NACKed read it clocks extra SCL pulses with SDA high and checks that the line stays high.

// File: rtl/i2creg_pkg.sv
// Package: shared constants and types for the I2C register-file target.
// Assumes a fixed map of seven 8-bit registers, register 0 read-only.
package i2creg_pkg;
    localparam int NUM_REGS  = 7;
    localparam int REG_W     = 8;
    localparam int PTR_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RX    = 3'd1,
        ST_ACK   = 3'd2,
        ST_TX    = 3'd3,
        ST_TXACK = 3'd4
    } bus_state_t;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_PTR  = 2'd1,
        K_DATA = 2'd2
    } byte_kind_t;

    // Writable-bit mask per register; reserved bits are cleared.
    function automatic logic [REG_W-1:0] wr_mask(input int idx);
        if (idx == 1 || idx == 5) return 8'hDF;
        else                      return 8'hFF;
    endfunction
endpackage

// File: rtl/i2c_bus_sampler.sv
// Module: synchronizes SCL and SDA and detects edges and bus conditions.
// Assumes clk oversamples SCL by several cycles per phase; idle bus is high.
module i2c_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_p, sda_p;

    assign raw = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // Shift each line through its synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // Keep the previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    a_r9_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/i2c_target_fsm.sv
// Module: I2C target protocol engine (address match, pointer, read/write bytes).
// Assumes conditions and edges come from i2c_bus_sampler; drives SDA open-drain.
module i2c_target_fsm
    import i2creg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h70
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [REG_W-1:0] rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic             sda_oe
);
    bus_state_t       state;
    byte_kind_t       kind;
    logic [2:0]       bitcnt;
    logic             full;
    logic             rw;
    logic             mack;
    logic [REG_W-1:0] shreg;
    logic [REG_W-1:0] txsh;

    // Main protocol sequencer: shifts bits, acknowledges, loads read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= K_ADDR;
            bitcnt  <= '0;
            full    <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            shreg   <= '0;
            txsh    <= '0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_RX;
                kind   <= K_ADDR;
                bitcnt <= '0;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: sda_oe <= 1'b0;
                    ST_RX: begin
                        if (scl_rise && !full) begin
                            shreg  <= {shreg[REG_W-2:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full   <= 1'b0;
                            bitcnt <= '0;
                            unique case (kind)
                                K_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end
                                K_PTR: begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_data <= shreg;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (kind == K_ADDR && rw) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                                kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
                            end
                            if (kind == K_DATA || (kind == K_ADDR && rw))
                                ptr <= ptr + 8'd1;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TXACK;
                            end else begin
                                txsh   <= {txsh[REG_W-2:0], 1'b0};
                                sda_oe <= ~txsh[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 8'd1;
                                state  <= ST_TX;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    a_r3_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    a_r4_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TXACK && scl_fall && !mack && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_oe));
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> (state == ST_IDLE && !sda_oe));
    a_r9_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && kind == K_ADDR && bitcnt == 3'd0 && !wr_en));
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: register storage with write masks and the read multiplexer.
// Assumes single-cycle write strobes; register 0 is assembled from inputs.
module cfg_reg_bank
    import i2creg_pkg::*;
#(
    parameter logic [3:0] VERSION = 4'h0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PTR_W-1:0]            ptr,
    input  logic [REG_W-1:0]            wr_data,
    input  logic                        spk_fault_i,
    input  logic                        thermal_i,
    output logic [REG_W-1:0]            rd_data,
    output logic [(NUM_REGS-1)*REG_W-1:0] regs_flat
);
    localparam int FLAT_W = (NUM_REGS - 1) * REG_W;

    genvar i;
    generate
        for (i = 1; i < NUM_REGS; i++) begin : g_reg
            logic [REG_W-1:0] q;
            // Store masked write data when this register is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && ptr == PTR_W'(i))
                    q <= wr_data & wr_mask(i);
            end
            assign regs_flat[(i-1)*REG_W +: REG_W] = q;
        end
    endgenerate

    // Select the read byte: status, stored register, or zero beyond the map.
    always_comb begin
        if (ptr == '0)
            rd_data = {VERSION, 2'b00, spk_fault_i, thermal_i};
        else if (ptr < PTR_W'(NUM_REGS))
            rd_data = regs_flat[(int'(ptr)-1)*REG_W +: REG_W];
        else
            rd_data = '0;
    end

    a_r7_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ptr == 8'd1 || ptr == 8'd5))
        |=> (regs_flat[5] == 1'b0 && regs_flat[4*REG_W+5] == 1'b0));
    a_r6_ignored_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ptr == '0 || ptr >= PTR_W'(NUM_REGS)))
        |=> $stable(regs_flat[FLAT_W-1:0]));
endmodule

// File: rtl/i2c_regfile_target.sv
// Module: top of the I2C register-file target; wires sampler, engine, bank.
// Assumes clk is at least ~16x the SCL rate; SDA pulled low while sda_oe=1.
module i2c_regfile_target
    import i2creg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h70,
    parameter logic [3:0] VERSION     = 4'h0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       spk_fault_i,
    input  logic       thermal_i,
    output logic [7:0] ctl_flags,
    output logic [4:0] atk_time,
    output logic [2:0] spk_lim,
    output logic [4:0] rel_time,
    output logic [2:0] hp_lim,
    output logic [2:0] amp_mode,
    output logic [4:0] mono_vol,
    output logic [7:0] spk_gain_cfg,
    output logic [7:0] hp_gain_cfg
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] ptr;
    logic [REG_W-1:0] wr_data, rd_data;
    logic [(NUM_REGS-1)*REG_W-1:0] regs_flat;

    i2c_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .sda_oe(sda_oe)
    );

    cfg_reg_bank #(.VERSION(VERSION)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
        .spk_fault_i(spk_fault_i), .thermal_i(thermal_i),
        .rd_data(rd_data), .regs_flat(regs_flat)
    );

    // Field decode of the stored registers (R10).
    assign ctl_flags    = regs_flat[0*8 +: 8];
    assign atk_time     = regs_flat[1*8+3 +: 5];
    assign spk_lim      = regs_flat[1*8 +: 3];
    assign rel_time     = regs_flat[2*8+3 +: 5];
    assign hp_lim       = regs_flat[2*8 +: 3];
    assign amp_mode     = regs_flat[3*8+5 +: 3];
    assign mono_vol     = regs_flat[3*8 +: 5];
    assign spk_gain_cfg = regs_flat[4*8 +: 8];
    assign hp_gain_cfg  = regs_flat[5*8 +: 8];
endmodule

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic spk_fault = 1'b0, thermal = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [7:0] ctl_flags, spk_gain_cfg, hp_gain_cfg;
    logic [4:0] atk_time, rel_time, mono_vol;
    logic [2:0] spk_lim, hp_lim, amp_mode;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] exp_v[$];
    string      exp_t[$];
    logic [7:0] act_v[$];

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    i2c_regfile_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .spk_fault_i(spk_fault), .thermal_i(thermal),
        .ctl_flags(ctl_flags), .atk_time(atk_time), .spk_lim(spk_lim),
        .rel_time(rel_time), .hp_lim(hp_lim), .amp_mode(amp_mode),
        .mono_vol(mono_vol), .spk_gain_cfg(spk_gain_cfg), .hp_gain_cfg(hp_gain_cfg)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = ~sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack);
        logic [7:0] b;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line}; tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        act_v.push_back(b);
        send_bit(~give_ack);
    endtask

    task automatic write_regs(input logic [7:0] p, input int n,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input logic [7:0] d3);
        logic a;
        logic [7:0] d[4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        i2c_start();
        send_byte(8'hE0, a); chk("R1 write address ack", a, 1);
        send_byte(p, a);     chk("R2 pointer ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a); chk("R2 data ack", a, 1);
        end
        i2c_stop();
    endtask

    task automatic read_regs(input logic [7:0] p, input int n);
        logic a;
        i2c_start();
        send_byte(8'hE0, a); chk("R3 address ack", a, 1);
        send_byte(p, a);     chk("R3 pointer ack", a, 1);
        i2c_start();
        send_byte(8'hE1, a); chk("R3 read address ack", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1);
        // R4: after NACK the line must stay released while clocked.
        for (int i = 0; i < 3; i++) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            chk("R4 released after NACK", sda_line, 1);
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        i2c_stop();
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_v.push_back(v);
        exp_t.push_back(tag);
    endtask

    // Scoreboard monitor: compares each byte read with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (act_v.size() > 0) begin
                logic [7:0] a;
                a = act_v.pop_front();
                if (exp_v.size() == 0) chk("R3 unexpected read byte", a, -1);
                else chk(exp_t.pop_front(), a, exp_v.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        tick(6);
        chk("R8 reset sda_oe", sda_oe, 0);
        chk("R8 reset ctl_flags", ctl_flags, 0);
        chk("R8 reset gains", {spk_gain_cfg, hp_gain_cfg}, 0);
        rst_n = 1'b1;
        tick(2 * Q);

        // R2/R7/R10: multi-byte write from register 1.
        write_regs(8'd1, 4, 8'hFF, 8'hAB, 8'h5C, 8'hE7);
        chk("R7 reserved bit in ctl_flags", ctl_flags, 8'hDF);
        chk("R10 atk_time", atk_time, 5'h15);
        chk("R10 spk_lim", spk_lim, 3);
        chk("R10 rel_time", rel_time, 5'h0B);
        chk("R10 hp_lim", hp_lim, 4);
        chk("R10 amp_mode", amp_mode, 7);
        chk("R10 mono_vol", mono_vol, 7);

        // R1: foreign address gets no ack and writes nothing.
        i2c_start();
        send_byte(8'hE4, a); chk("R1 foreign address no ack", a, 0);
        send_byte(8'h01, a); chk("R1 no ack after mismatch", a, 0);
        send_byte(8'h00, a); chk("R1 no ack after mismatch data", a, 0);
        i2c_stop();
        chk("R1 no write after mismatch", ctl_flags, 8'hDF);

        // R3/R5: read registers 0..5 with fault=1, thermal=0.
        spk_fault = 1'b1; thermal = 1'b0;
        expect_byte(8'h02, "R5 status read fault");
        expect_byte(8'hDF, "R3 read reg1");
        expect_byte(8'hAB, "R3 read reg2");
        expect_byte(8'h5C, "R3 read reg3");
        expect_byte(8'hE7, "R3 read reg4");
        expect_byte(8'h00, "R3 read reg5");
        read_regs(8'd0, 6);

        // R6/R7: write across 5, 6 and 7; write to register 0.
        write_regs(8'd5, 3, 8'h24, 8'h33, 8'h77, 8'h00);
        chk("R7 reserved bit in spk_gain_cfg", spk_gain_cfg, 8'h04);
        chk("R10 hp_gain_cfg", hp_gain_cfg, 8'h33);
        write_regs(8'd0, 1, 8'hFF, 8'h00, 8'h00, 8'h00);
        expect_byte(8'h33, "R3 read reg6");
        expect_byte(8'h00, "R6 read beyond map");
        read_regs(8'd6, 2);
        spk_fault = 1'b0; thermal = 1'b1;
        expect_byte(8'h01, "R6 R5 reg0 unwritten, thermal sampled");
        expect_byte(8'hDF, "R3 read reg1 again");
        read_regs(8'd0, 2);

        // R9: stop in the middle of a data byte stores nothing.
        i2c_start();
        send_byte(8'hE0, a); chk("R9 address ack", a, 1);
        send_byte(8'h01, a); chk("R9 pointer ack", a, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i2c_stop();
        chk("R9 partial byte not stored", ctl_flags, 8'hDF);
        write_regs(8'd1, 1, 8'h00, 8'h00, 8'h00, 8'h00);
        chk("R9 next transfer after abort", ctl_flags, 8'h00);

        // R9: repeated start in the middle of an address byte.
        i2c_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        i2c_start();
        send_byte(8'hE0, a); chk("R9 ack after mid-byte restart", a, 1);
        send_byte(8'h04, a); chk("R9 pointer ack after restart", a, 1);
        send_byte(8'h10, a); chk("R9 data ack after restart", a, 1);
        i2c_stop();
        chk("R10 mono_vol after restart", mono_vol, 5'h10);
        chk("R10 amp_mode after restart", amp_mode, 0);

        tick(4);
        chk("R3 all expected reads seen", exp_v.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule